// File: doc/BRIEF.md
# Interrupt Controller Host Register Interface

This block is the byte-wide host-side register port of one eight-input interrupt controller. It has two addresses, selected by a single address bit: a command port (address bit 0) and a data port (address bit 1). After reset the controller is not ready. Software must first run a three- or four-byte initialization sequence. The first byte goes to the command port, and the remaining bytes go one after another to the data port, which is shared with the mask register. After that, data-port writes load the mask, and command-port writes are decoded as either an end-of-interrupt/priority command or a read/mask-mode control word.

The block holds the configuration the external priority core needs: the vector base, the mask, auto end-of-interrupt, special nesting, special masking and the rotate flag. It also issues one-cycle strobes for end-of-interrupt, set-priority, initialization clear and acknowledge. Reads return the request register, the in-service register or the mask. When a poll is armed, a read returns the winning pin reported by the core, and the same read acknowledges that pin.

Top module: `pic_host_port`

## Requirements
- R1: After reset, cfg_ready, cfg_mask, cfg_vbase, cfg_aeoi, cfg_sfnm, cfg_smm, cfg_rotate and all strobes are 0.
- R2: A command-port write with bit 4 set starts initialization. On the next cycle cmd_init pulses, cfg_ready is 0, cfg_mask is 0 and cfg_smm is 0. The read select returns to the request register and any armed poll is dropped. This applies whether or not the controller was ready.
- R3: That start byte is rejected if bit 1 (single mode) is set or bit 0 (fourth byte needed) is clear. On rejection acc_err pulses and the sequence does not advance, so the next data-port write loads the mask.
- R4: After an accepted start byte, the next data-port write sets cfg_vbase to the byte ANDed with 0xF8. The data-port write after that is consumed without effect: cfg_mask stays 0.
- R5: The third data-port write of the sequence is accepted only if its bit 0 is set. If it is accepted, cfg_ready becomes 1, cfg_aeoi takes bit 1, and cfg_sfnm takes bit 4 on a master instance (IS_MASTER=1) but stays 0 on a slave. If it is rejected, acc_err pulses and the next data-port write is again treated as this byte.
- R6: While not ready, command-port writes with bit 4 clear have no effect.
- R7: Once ready, a data-port write loads cfg_mask, and a data-port read returns it.
- R8: A ready command-port write with bits 4 and 3 clear sets cfg_rotate to bit 7. If bit 5 is set, cmd_eoi pulses with cmd_eoi_spec equal to bit 6 and cmd_level equal to bits 2:0.
- R9: Such a write with bit 5 clear, bit 6 set and bit 7 set pulses cmd_setpri with cmd_level equal to bits 2:0. With any other bit 7/6 combination it pulses nothing, and cmd_eoi and cmd_setpri never pulse together.
- R10: A ready command-port write with bit 3 set updates cfg_smm from bit 5 only when bit 6 is set.
- R11: In that same write, if bit 1 is set, bit 0 selects what a command-port read returns (1 for core_isr, 0 for core_irr) and bit 2 arms the poll. If bit 1 is clear, neither changes.
- R12: A read on either port while the poll is armed disarms it. If core_win_vld is high, the read returns 0x80 OR core_win_pin and cmd_ack pulses with that pin. If core_win_vld is low, the read returns 0 and there is no acknowledge.
- R13: An access whose acc_size is not 1 pulses acc_err and changes nothing. A refused read does not raise acc_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe (ignored when acc_wr is high) |
| acc_a0 | input | 1 | Address bit: 0 command port, 1 data port |
| acc_size | input | SZW | Access width in bytes; only 1 is served |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte, valid with acc_rvalid |
| acc_rvalid | output | 1 | Read data valid |
| acc_err | output | 1 | Rejected byte or refused access |
| core_irr | input | 8 | Request register of the priority core |
| core_isr | input | 8 | In-service register of the priority core |
| core_win_vld | input | 1 | Core has an eligible request |
| core_win_pin | input | 3 | Highest eligible pin |
| cfg_ready | output | 1 | Initialization complete |
| cfg_vbase | output | 8 | Vector base, low three bits zero |
| cfg_mask | output | 8 | Interrupt mask |
| cfg_aeoi | output | 1 | Auto end-of-interrupt mode |
| cfg_sfnm | output | 1 | Special nesting mode |
| cfg_smm | output | 1 | Special mask mode |
| cfg_rotate | output | 1 | Rotate flag of the last priority command |
| cmd_init | output | 1 | Pulse: clear requests, lowest priority to pin 7 |
| cmd_eoi | output | 1 | Pulse: end of interrupt |
| cmd_eoi_spec | output | 1 | End of interrupt names a pin |
| cmd_setpri | output | 1 | Pulse: set lowest-priority pin |
| cmd_level | output | 3 | Pin for cmd_eoi or cmd_setpri |
| cmd_ack | output | 1 | Pulse: acknowledge from poll read |
| cmd_ack_pin | output | 3 | Pin acknowledged |

## Verification
Every result is registered once. A write or read presented before a clock edge shows its effect on the configuration, strobe and read outputs in the cycle that follows that edge. A strobe lasts exactly that one cycle. The bench drives each access on a falling edge, withdraws it on the next falling edge, and samples at that moment, which falls inside the one cycle where the strobes are live. Register state is checked through the outputs and through read-back, and the read-select and poll state are always observed on the next read.

// File: rtl/pic_if_pkg.sv
package pic_if_pkg;

    localparam int DW   = 8;
    localparam int PINW = 3;

    // command-port discrimination
    localparam int CMD_START_BIT = 4;
    localparam int CMD_CTRL_BIT  = 3;
    // start byte
    localparam int ST_NEED4_BIT  = 0;
    localparam int ST_SINGLE_BIT = 1;
    // final init byte
    localparam int FIN_CPU_BIT   = 0;
    localparam int FIN_AUTO_BIT  = 1;
    localparam int FIN_NEST_BIT  = 4;
    // priority command
    localparam int PC_ROT_BIT    = 7;
    localparam int PC_SEL_BIT    = 6;
    localparam int PC_END_BIT    = 5;
    // control word
    localparam int CW_MSKEN_BIT  = 6;
    localparam int CW_MSK_BIT    = 5;
    localparam int CW_POLL_BIT   = 2;
    localparam int CW_RDEN_BIT   = 1;
    localparam int CW_RDSEL_BIT  = 0;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_BAD,
        ACC_START,
        ACC_DWR,
        ACC_PCMD,
        ACC_CTRL,
        ACC_RD
    } acc_kind_e;

    typedef enum logic [1:0] {
        STEP_MASK,
        STEP_BASE,
        STEP_SKIP,
        STEP_FIN
    } init_step_e;

    typedef struct packed {
        logic               ready;
        init_step_e         step;
        logic [DW-PINW-1:0] vbase;
        logic [DW-1:0]      mask;
        logic               aeoi;
        logic               sfnm;
        logic               smm;
        logic               poll;
        logic               rd_isr;
        logic               err;
        logic               init;
    } cfg_state_t;

    typedef struct packed {
        logic            rotate;
        logic            eoi;
        logic            eoi_spec;
        logic            setpri;
        logic [PINW-1:0] level;
    } cmd_state_t;

    typedef struct packed {
        logic [DW-1:0]   rdata;
        logic            rvalid;
        logic            ack;
        logic [PINW-1:0] ack_pin;
    } rd_state_t;

endpackage

// File: rtl/pic_acc_decode.sv
module pic_acc_decode
    import pic_if_pkg::*;
#(
    parameter int SZW = 3
) (
    input  logic           acc_wr,
    input  logic           acc_rd,
    input  logic           acc_a0,
    input  logic [SZW-1:0] acc_size,
    input  logic           wd_start,
    input  logic           wd_ctrl,
    input  logic           ready,
    output acc_kind_e      kind
);

    localparam logic [SZW-1:0] ONE_BYTE = SZW'(1);

    always_comb begin
        kind = ACC_NONE;
        if ((acc_wr || acc_rd) && acc_size != ONE_BYTE) begin
            kind = ACC_BAD;
        end else if (acc_wr) begin
            if (acc_a0)
                kind = ACC_DWR;
            else if (wd_start)
                kind = ACC_START;
            else if (ready)
                kind = wd_ctrl ? ACC_CTRL : ACC_PCMD;
        end else if (acc_rd) begin
            kind = ACC_RD;
        end
    end

endmodule

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
    import pic_if_pkg::*;
#(
    parameter bit IS_MASTER = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  acc_kind_e     kind,
    input  logic [DW-1:0] wdata,
    output cfg_state_t    cfg_q
);

    cfg_state_t cfg_d;

    always_comb begin
        cfg_d      = cfg_q;
        cfg_d.err  = 1'b0;
        cfg_d.init = 1'b0;
        case (kind)
            ACC_BAD: cfg_d.err = 1'b1;
            ACC_START: begin
                cfg_d.ready  = 1'b0;
                cfg_d.mask   = '0;
                cfg_d.smm    = 1'b0;
                cfg_d.poll   = 1'b0;
                cfg_d.rd_isr = 1'b0;
                cfg_d.init   = 1'b1;
                if (wdata[ST_SINGLE_BIT] || !wdata[ST_NEED4_BIT]) begin
                    cfg_d.err  = 1'b1;
                    cfg_d.step = STEP_MASK;
                end else begin
                    cfg_d.step = STEP_BASE;
                end
            end
            ACC_DWR: begin
                case (cfg_q.step)
                    STEP_BASE: begin
                        cfg_d.vbase = wdata[DW-1:PINW];
                        cfg_d.step  = STEP_SKIP;
                    end
                    STEP_SKIP: cfg_d.step = STEP_FIN;
                    STEP_FIN: begin
                        if (!wdata[FIN_CPU_BIT]) begin
                            cfg_d.err = 1'b1;
                        end else begin
                            cfg_d.ready = 1'b1;
                            cfg_d.step  = STEP_MASK;
                            cfg_d.aeoi  = wdata[FIN_AUTO_BIT];
                            cfg_d.sfnm  = IS_MASTER && wdata[FIN_NEST_BIT];
                        end
                    end
                    default: cfg_d.mask = wdata;
                endcase
            end
            ACC_CTRL: begin
                if (wdata[CW_MSKEN_BIT])
                    cfg_d.smm = wdata[CW_MSK_BIT];
                if (wdata[CW_RDEN_BIT]) begin
                    cfg_d.rd_isr = wdata[CW_RDSEL_BIT];
                    cfg_d.poll   = wdata[CW_POLL_BIT];
                end
            end
            ACC_RD: cfg_d.poll = 1'b0;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else
            cfg_q <= cfg_d;
    end

    AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.init |-> (!cfg_q.ready && cfg_q.mask == '0 && !cfg_q.poll)); // R2

    AST_READY_FROM_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_q.ready) |-> $past(kind == ACC_DWR && cfg_q.step == STEP_FIN)); // R5

    AST_REFUSED_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        kind == ACC_BAD |=> ($stable(cfg_q.mask) && $stable(cfg_q.ready) && cfg_q.err)); // R13

    AST_SLAVE_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        !IS_MASTER |-> !cfg_q.sfnm); // R5

endmodule

// File: rtl/pic_cmd_strobe.sv
module pic_cmd_strobe
    import pic_if_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  acc_kind_e       kind,
    input  logic            pc_rot,
    input  logic            pc_sel,
    input  logic            pc_end,
    input  logic [PINW-1:0] pc_lvl,
    output cmd_state_t      cmd_q
);

    cmd_state_t cmd_d;

    always_comb begin
        cmd_d          = cmd_q;
        cmd_d.eoi      = 1'b0;
        cmd_d.eoi_spec = 1'b0;
        cmd_d.setpri   = 1'b0;
        if (kind == ACC_PCMD) begin
            cmd_d.rotate = pc_rot;
            if (pc_end) begin
                cmd_d.eoi      = 1'b1;
                cmd_d.eoi_spec = pc_sel;
                cmd_d.level    = pc_lvl;
            end else if (pc_sel && pc_rot) begin
                cmd_d.setpri = 1'b1;
                cmd_d.level  = pc_lvl;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else
            cmd_q <= cmd_d;
    end

    AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_q.eoi, cmd_q.setpri})); // R9

    AST_STROBE_ONLY_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q.eoi || cmd_q.setpri) |-> $past(kind == ACC_PCMD)); // R8

endmodule

// File: rtl/pic_rd_port.sv
module pic_rd_port
    import pic_if_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  acc_kind_e       kind,
    input  logic            acc_a0,
    input  logic            poll_q,
    input  logic            rd_isr_q,
    input  logic [DW-1:0]   mask_q,
    input  logic [DW-1:0]   core_irr,
    input  logic [DW-1:0]   core_isr,
    input  logic            core_win_vld,
    input  logic [PINW-1:0] core_win_pin,
    output rd_state_t       rd_q
);

    rd_state_t rd_d;

    always_comb begin
        rd_d        = rd_q;
        rd_d.rvalid = 1'b0;
        rd_d.ack    = 1'b0;
        if (kind == ACC_RD) begin
            rd_d.rvalid = 1'b1;
            if (poll_q) begin
                if (core_win_vld) begin
                    rd_d.rdata   = {1'b1, {(DW-1-PINW){1'b0}}, core_win_pin};
                    rd_d.ack     = 1'b1;
                    rd_d.ack_pin = core_win_pin;
                end else begin
                    rd_d.rdata = '0;
                end
            end else if (acc_a0) begin
                rd_d.rdata = mask_q;
            end else begin
                rd_d.rdata = rd_isr_q ? core_isr : core_irr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else
            rd_q <= rd_d;
    end

    AST_ACK_MATCHES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q.ack |-> (rd_q.rvalid && rd_q.rdata[DW-1] && rd_q.rdata[PINW-1:0] == rd_q.ack_pin)); // R12

    AST_ACK_NEEDS_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q.ack |-> $past(poll_q && core_win_vld)); // R12

endmodule

// File: rtl/pic_host_port.sv
module pic_host_port
    import pic_if_pkg::*;
#(
    parameter bit IS_MASTER = 1'b1,
    parameter int SZW       = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_wr,
    input  logic            acc_rd,
    input  logic            acc_a0,
    input  logic [SZW-1:0]  acc_size,
    input  logic [7:0]      acc_wdata,
    output logic [7:0]      acc_rdata,
    output logic            acc_rvalid,
    output logic            acc_err,
    input  logic [7:0]      core_irr,
    input  logic [7:0]      core_isr,
    input  logic            core_win_vld,
    input  logic [2:0]      core_win_pin,
    output logic            cfg_ready,
    output logic [7:0]      cfg_vbase,
    output logic [7:0]      cfg_mask,
    output logic            cfg_aeoi,
    output logic            cfg_sfnm,
    output logic            cfg_smm,
    output logic            cfg_rotate,
    output logic            cmd_init,
    output logic            cmd_eoi,
    output logic            cmd_eoi_spec,
    output logic            cmd_setpri,
    output logic [2:0]      cmd_level,
    output logic            cmd_ack,
    output logic [2:0]      cmd_ack_pin
);

    acc_kind_e  kind;
    cfg_state_t cfg_q;
    cmd_state_t cmd_q;
    rd_state_t  rd_q;

    pic_acc_decode #(.SZW(SZW)) u_dec (
        .acc_wr   (acc_wr),
        .acc_rd   (acc_rd),
        .acc_a0   (acc_a0),
        .acc_size (acc_size),
        .wd_start (acc_wdata[CMD_START_BIT]),
        .wd_ctrl  (acc_wdata[CMD_CTRL_BIT]),
        .ready    (cfg_q.ready),
        .kind     (kind)
    );

    pic_cfg_regs #(.IS_MASTER(IS_MASTER)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .wdata (acc_wdata),
        .cfg_q (cfg_q)
    );

    pic_cmd_strobe u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .kind   (kind),
        .pc_rot (acc_wdata[PC_ROT_BIT]),
        .pc_sel (acc_wdata[PC_SEL_BIT]),
        .pc_end (acc_wdata[PC_END_BIT]),
        .pc_lvl (acc_wdata[PINW-1:0]),
        .cmd_q  (cmd_q)
    );

    pic_rd_port u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .kind         (kind),
        .acc_a0       (acc_a0),
        .poll_q       (cfg_q.poll),
        .rd_isr_q     (cfg_q.rd_isr),
        .mask_q       (cfg_q.mask),
        .core_irr     (core_irr),
        .core_isr     (core_isr),
        .core_win_vld (core_win_vld),
        .core_win_pin (core_win_pin),
        .rd_q         (rd_q)
    );

    assign acc_rdata    = rd_q.rdata;
    assign acc_rvalid   = rd_q.rvalid;
    assign acc_err      = cfg_q.err;
    assign cfg_ready    = cfg_q.ready;
    assign cfg_vbase    = {cfg_q.vbase, {PINW{1'b0}}};
    assign cfg_mask     = cfg_q.mask;
    assign cfg_aeoi     = cfg_q.aeoi;
    assign cfg_sfnm     = cfg_q.sfnm;
    assign cfg_smm      = cfg_q.smm;
    assign cfg_rotate   = cmd_q.rotate;
    assign cmd_init     = cfg_q.init;
    assign cmd_eoi      = cmd_q.eoi;
    assign cmd_eoi_spec = cmd_q.eoi_spec;
    assign cmd_setpri   = cmd_q.setpri;
    assign cmd_level    = cmd_q.level;
    assign cmd_ack      = rd_q.ack;
    assign cmd_ack_pin  = rd_q.ack_pin;

    AST_REFUSED_READ_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && !acc_wr && acc_size != SZW'(1)) |=> (!acc_rvalid && acc_err)); // R13

    AST_NOT_READY_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && !acc_a0 && !acc_wdata[CMD_START_BIT] && !cfg_ready)
        |=> (!cmd_eoi && !cmd_setpri && $stable(cfg_smm))); // R6

endmodule

// File: tb/tb_pic_host_port.sv
module tb_pic_host_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_wr = 1'b0, acc_rd = 1'b0, acc_a0 = 1'b0;
    logic [2:0] acc_size = 3'd1;
    logic [7:0] acc_wdata = 8'h00;
    logic [7:0] core_irr = 8'h00, core_isr = 8'h00;
    logic       core_win_vld = 1'b0;
    logic [2:0] core_win_pin = 3'd0;

    logic [7:0] acc_rdata, cfg_vbase, cfg_mask;
    logic       acc_rvalid, acc_err, cfg_ready, cfg_aeoi, cfg_sfnm, cfg_smm, cfg_rotate;
    logic       cmd_init, cmd_eoi, cmd_eoi_spec, cmd_setpri, cmd_ack;
    logic [2:0] cmd_level, cmd_ack_pin;

    logic [7:0] s_rdata, s_vbase, s_mask;
    logic       s_rvalid, s_err, s_ready, s_aeoi, s_sfnm, s_smm, s_rotate;
    logic       s_init, s_eoi, s_eoi_spec, s_setpri, s_ack;
    logic [2:0] s_level, s_ack_pin;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    pic_host_port #(.IS_MASTER(1'b1), .SZW(3)) dut (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_a0(acc_a0),
        .acc_size(acc_size), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_rvalid(acc_rvalid), .acc_err(acc_err), .core_irr(core_irr),
        .core_isr(core_isr), .core_win_vld(core_win_vld), .core_win_pin(core_win_pin),
        .cfg_ready(cfg_ready), .cfg_vbase(cfg_vbase), .cfg_mask(cfg_mask),
        .cfg_aeoi(cfg_aeoi), .cfg_sfnm(cfg_sfnm), .cfg_smm(cfg_smm),
        .cfg_rotate(cfg_rotate), .cmd_init(cmd_init), .cmd_eoi(cmd_eoi),
        .cmd_eoi_spec(cmd_eoi_spec), .cmd_setpri(cmd_setpri), .cmd_level(cmd_level),
        .cmd_ack(cmd_ack), .cmd_ack_pin(cmd_ack_pin)
    );

    pic_host_port #(.IS_MASTER(1'b0), .SZW(3)) dut_slv (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_a0(acc_a0),
        .acc_size(acc_size), .acc_wdata(acc_wdata), .acc_rdata(s_rdata),
        .acc_rvalid(s_rvalid), .acc_err(s_err), .core_irr(core_irr),
        .core_isr(core_isr), .core_win_vld(core_win_vld), .core_win_pin(core_win_pin),
        .cfg_ready(s_ready), .cfg_vbase(s_vbase), .cfg_mask(s_mask),
        .cfg_aeoi(s_aeoi), .cfg_sfnm(s_sfnm), .cfg_smm(s_smm),
        .cfg_rotate(s_rotate), .cmd_init(s_init), .cmd_eoi(s_eoi),
        .cmd_eoi_spec(s_eoi_spec), .cmd_setpri(s_setpri), .cmd_level(s_level),
        .cmd_ack(s_ack), .cmd_ack_pin(s_ack_pin)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // one access: driven on a falling edge, sampled on the following falling edge
    task automatic acc(input logic w, input logic r, input logic a0,
                       input logic [2:0] sz, input logic [7:0] d);
        @(negedge clk);
        acc_wr = w; acc_rd = r; acc_a0 = a0; acc_size = sz; acc_wdata = d;
        @(negedge clk);
        acc_wr = 1'b0; acc_rd = 1'b0; acc_size = 3'd1;
    endtask

    task automatic wrc(input logic [7:0] d); acc(1'b1, 1'b0, 1'b0, 3'd1, d); endtask
    task automatic wrd(input logic [7:0] d); acc(1'b1, 1'b0, 1'b1, 3'd1, d); endtask
    task automatic rdc(); acc(1'b0, 1'b1, 1'b0, 3'd1, 8'h00); endtask
    task automatic rdd(); acc(1'b0, 1'b1, 1'b1, 3'd1, 8'h00); endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ready", cfg_ready, 0);
        chk("R1 mask", cfg_mask, 0);
        chk("R1 vbase", cfg_vbase, 0);
        chk("R1 flags", {cfg_aeoi, cfg_sfnm, cfg_smm, cfg_rotate}, 0);
        chk("R1 strobes", {cmd_init, cmd_eoi, cmd_setpri, cmd_ack, acc_rvalid, acc_err}, 0);

        // R6 commands ignored before ready
        core_irr = 8'h5A; core_isr = 8'hA5; core_win_vld = 1'b1; core_win_pin = 3'd3;
        wrc(8'h0F);
        rdc();
        chk("R6 control word ignored", acc_rdata, 8'h5A);
        chk("R6 no ack", cmd_ack, 0);
        wrc(8'hA0);
        chk("R6 no eoi", cmd_eoi, 0);
        chk("R6 rotate unchanged", cfg_rotate, 0);

        // R3 rejected start bytes
        wrc(8'h10);
        chk("R3 err no need4", acc_err, 1);
        chk("R2 init pulse", cmd_init, 1);
        wrd(8'h3C);
        chk("R3 data goes to mask", cfg_mask, 8'h3C);
        chk("R3 still not ready", cfg_ready, 0);
        wrc(8'h13);
        chk("R3 err single", acc_err, 1);
        wrd(8'h5A);
        chk("R3 mask after single", cfg_mask, 8'h5A);

        // R4 vector base sweep, ICW3 slot consumed
        for (int i = 0; i < 32; i++) begin
            logic [7:0] v;
            v = 8'((i << 3) | (i % 8));
            wrc(8'h11);
            chk("R2 init on start", cmd_init, 1);
            chk("R3 good start no err", acc_err, 0);
            chk("R2 mask cleared", cfg_mask, 0);
            wrd(v);
            chk("R4 vbase", cfg_vbase, v & 8'hF8);
            chk("R4 mask not loaded", cfg_mask, 0);
            wrd(8'hFF);
            chk("R4 skip byte ignored", cfg_mask, 0);
            wrd(8'h01);
            chk("R5 ready", cfg_ready, 1);
        end

        // R5 final byte sweep
        for (int j = 0; j < 8; j++) begin
            logic [7:0] f;
            f = {3'b000, j[2], 2'b00, j[1], j[0]};
            wrc(8'h11); wrd(8'h40); wrd(8'h00);
            wrd(f);
            if (j[0]) begin
                chk("R5 accepted ready", cfg_ready, 1);
                chk("R5 no err", acc_err, 0);
                chk("R5 aeoi", cfg_aeoi, j[1]);
                chk("R5 sfnm master", cfg_sfnm, j[2]);
                chk("R5 sfnm slave", s_sfnm, 0);
            end else begin
                chk("R5 rejected err", acc_err, 1);
                chk("R5 rejected not ready", cfg_ready, 0);
                wrd(8'h01);
                chk("R5 retry ready", cfg_ready, 1);
                chk("R5 retry aeoi", cfg_aeoi, 0);
            end
        end

        // R7 mask sweep with read-back
        for (int v = 0; v < 256; v++) begin
            wrd(8'(v));
            chk("R7 mask", cfg_mask, v);
            rdd();
            chk("R7 read mask", acc_rdata, v);
            chk("R7 rvalid", acc_rvalid, 1);
        end

        // R8 R9 priority command sweep
        for (int k = 0; k < 64; k++) begin
            logic [7:0] c;
            logic e_eoi, e_set;
            c = {k[5:3], 2'b00, k[2:0]};
            e_eoi = c[5];
            e_set = !c[5] && c[6] && c[7];
            wrc(c);
            chk("R8 rotate", cfg_rotate, c[7]);
            chk("R8 eoi", cmd_eoi, e_eoi);
            chk("R8 eoi specific", cmd_eoi_spec, e_eoi && c[6]);
            chk("R9 setpri", cmd_setpri, e_set);
            if (e_eoi || e_set) chk("R8 R9 level", cmd_level, c[2:0]);
        end

        // R10 special mask mode
        wrc(8'h68);
        chk("R10 smm set", cfg_smm, 1);
        wrc(8'h28);
        chk("R10 smm kept without enable", cfg_smm, 1);
        wrc(8'h48);
        chk("R10 smm cleared", cfg_smm, 0);

        // R11 read select
        for (int p = 0; p < 4; p++) begin
            core_irr = 8'(8'h11 * (p + 1));
            core_isr = 8'(8'hF0 >> p);
            wrc(8'h0B);
            rdc();
            chk("R11 isr select", acc_rdata, core_isr);
            wrc(8'h08);
            rdc();
            chk("R11 select kept", acc_rdata, core_isr);
            wrc(8'h0A);
            rdc();
            chk("R11 irr select", acc_rdata, core_irr);
        end
        rdd();
        chk("R11 data read mask", acc_rdata, 8'hFF);
        wrc(8'h0C);
        rdc();
        chk("R11 poll needs read enable", acc_rdata, core_irr);
        chk("R11 no ack", cmd_ack, 0);

        // R12 poll reads
        for (int p = 0; p < 8; p++) begin
            core_win_vld = 1'b1; core_win_pin = 3'(p);
            wrc(8'h0E);
            rdd();
            chk("R12 poll word", acc_rdata, 8'h80 | p);
            chk("R12 ack", cmd_ack, 1);
            chk("R12 ack pin", cmd_ack_pin, p);
            rdc();
            chk("R12 poll disarmed", acc_rdata, core_irr);
            chk("R12 single ack", cmd_ack, 0);
        end
        core_win_vld = 1'b0;
        wrc(8'h0E);
        rdc();
        chk("R12 empty poll", acc_rdata, 0);
        chk("R12 empty no ack", cmd_ack, 0);
        chk("R12 empty rvalid", acc_rvalid, 1);

        // R13 refused accesses
        acc(1'b1, 1'b0, 1'b1, 3'd2, 8'h33);
        chk("R13 wide write err", acc_err, 1);
        chk("R13 mask kept", cfg_mask, 8'hFF);
        acc(1'b0, 1'b1, 1'b0, 3'd0, 8'h00);
        chk("R13 refused read no rvalid", acc_rvalid, 0);
        chk("R13 refused read err", acc_err, 1);
        acc(1'b1, 1'b0, 1'b0, 3'd4, 8'h11);
        chk("R13 wide start ignored", {cfg_ready, cmd_init}, 2'b10);

        // R2 restart from ready clears state
        wrc(8'h68);
        wrc(8'h0F);
        wrc(8'h11);
        chk("R2 init", cmd_init, 1);
        chk("R2 not ready", cfg_ready, 0);
        chk("R2 mask", cfg_mask, 0);
        chk("R2 smm", cfg_smm, 0);
        core_win_vld = 1'b1;
        rdc();
        chk("R2 select and poll cleared", acc_rdata, core_irr);
        chk("R2 no ack", cmd_ack, 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule